// File: doc/BRIEF.md
# Paged Host Control Register File

This block is the host-side control and status register set of a network interface controller. The host reaches it through a 16-bit word window addressed by a 5-bit byte offset. A paging register picks one of eight register pages. The offsets from 0x00 to 0x06 are shared and reach the same registers whatever page is active.

The shared area holds four things: a fixed hardware identifier, the paging register (whose read also returns a card identifier), and two option words. The option words are changed with a masked write: one bit per byte lane carries the value, and every other bit set in the written word picks which bits take that value. The option words carry:
- the core reset release and the interrupt enable;
- two command bits that the transmit and receive engines clear when they finish;
- a non-volatile-memory load bit that stays busy for a programmable number of cycles.

Page 0 holds a sticky interrupt status register, cleared by writing 1, and an interrupt mask register. Page 4 holds three saturating error counters that clear when read. Event inputs come from the MAC and from the transmit and receive engines.

Top module: `paged_csr_block`

## Requirements
- R1: After reset the active page is 0, both option words read 0x0000, interrupt status and mask read 0x0000, all counters read 0, and `irq`, `core_rst_n`, `tx_req` and `adv_req` are 0.
- R2: A write to offset 0x02 loads bits 2:0 of the written word as the active page. A read of 0x02 returns `CARD_ID` in bits 15:4 and the page in bits 3:0 (bit 3 always 0). Offsets 0x00, 0x02, 0x04 and 0x06 behave the same on every page.
- R3: A write to an option word (0x04 low word, 0x06 high word) works per byte lane. Every bit from 7 down to 1 that is written as 1 takes the value of written bit 0. Every bit from 15 down to 9 that is written as 1 takes the value of written bit 8. Bits written as 0 keep their state. Bits 0 and 8 of both option words always read 0.
- R4: `core_rst_n` equals bit 1 of the low option word, so the core is held in reset while that bit is 0. Bit 2 of the low option word is the interrupt enable.
- R5: Interrupt status bits are set by one-cycle event pulses: receive packet in bit 10, receive error in bit 9, transmit space in bit 4, transmit complete in bit 3, transmit error in bit 1. Writing 1 to a status bit at page-0 offset 0x08 clears it. An event in the same cycle as its clear leaves the bit set.
- R6: The interrupt mask at page-0 offset 0x0A stores only bits 10, 9, 4, 3 and 1. `irq` is 1 exactly when the interrupt enable is 1 and some status bit is set under a set mask bit.
- R7: The transmit-command bit is bit 1 of the high option word and drives `tx_req`. The advance-packet bit is bit 2 and drives `adv_req`. A one-cycle pulse on `tx_ack` or `adv_ack` clears the matching bit. A masked write in the same cycle as the acknowledge takes effect over it.
- R8: Bit 6 of the high option word is the memory-load bit. A high-word write with bit 6 set and bit 0 set, made while no load is running, starts a load. Bit 6 then reads 1 for exactly `EE_LOAD_CYCLES` cycles after that write, and 0 afterwards. Writes to bit 6 during a load, and writes of value 0 to it, have no effect.
- R9: On page 4, offset 0x10 returns the dropped-packet count in bits 11:0. Offset 0x12 returns the CRC-error count in bits 7:0 and the transmit-abort count in bits 15:8. Reading an offset clears the counters it returns. If an event arrives in the same cycle as the read, the counter becomes 1.
- R10: Each counter stops at its all-ones value and does not wrap.
- R11: The identifier offset 0x00 ignores writes. Page-0 and page-4 registers are neither written nor cleared by accesses made while another page is active, and such reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte offset of the word access (even offsets decode) |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; read side effects happen at the clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address and current state |
| ev_rx_pkt | input | 1 | Receive packet event pulse |
| ev_rx_err | input | 1 | Receive error event pulse |
| ev_tx_space | input | 1 | Transmit space available event pulse |
| ev_tx_cmpl | input | 1 | Transmit complete event pulse |
| ev_tx_err | input | 1 | Transmit error event pulse |
| ev_drop | input | 1 | Dropped packet count pulse |
| ev_crc | input | 1 | CRC error count pulse |
| ev_abort | input | 1 | Transmit abort count pulse |
| tx_ack | input | 1 | Transmit command finished |
| adv_ack | input | 1 | Advance-packet command finished |
| irq | output | 1 | Interrupt request |
| core_rst_n | output | 1 | Core reset, active low |
| tx_req | output | 1 | Transmit command pending |
| adv_req | output | 1 | Advance-packet command pending |

## Verification
Read data is combinational, so a read result is due in the same cycle as the strobe. The bench samples it shortly after driving the access and before the edge, and the value it expects still reflects the old state. Every write, clear, event and acknowledge takes effect at the next rising edge. So `irq`, `core_rst_n`, `tx_req`, `adv_req` and the next read show the change one cycle after the stimulus. The bench checks these outputs at the falling edge that follows each rising edge. The memory-load bit is read on every cycle of its busy window, which pins its fall to exactly `EE_LOAD_CYCLES` cycles after the starting write.

// File: rtl/pcsr_pkg.sv
package pcsr_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned OFS_W  = 5;
  localparam int unsigned PAGE_W = 3;
  localparam int unsigned PSEL_W = 4;

  localparam logic [OFS_W-1:0] OFS_ID     = 5'h00;
  localparam logic [OFS_W-1:0] OFS_PAGE   = 5'h02;
  localparam logic [OFS_W-1:0] OFS_OPT_LO = 5'h04;
  localparam logic [OFS_W-1:0] OFS_OPT_HI = 5'h06;
  localparam logic [OFS_W-1:0] OFS_IRQ_ST = 5'h08;
  localparam logic [OFS_W-1:0] OFS_IRQ_MK = 5'h0A;
  localparam logic [OFS_W-1:0] OFS_DROP   = 5'h10;
  localparam logic [OFS_W-1:0] OFS_ERRS   = 5'h12;

  localparam logic [PAGE_W-1:0] PG_PERF = 3'd0;
  localparam logic [PAGE_W-1:0] PG_LAN  = 3'd4;

  // interrupt sources: index -> status bit position
  localparam int unsigned N_IRQ = 5;
  localparam int IRQ_POS [N_IRQ] = '{10, 9, 4, 3, 1};

  localparam int unsigned OPT_CORE_RUN = 1;
  localparam int unsigned OPT_IRQ_EN   = 2;
  localparam int unsigned CMD_TX       = 1;
  localparam int unsigned CMD_ADV      = 2;
  localparam int unsigned CMD_MEMLOAD  = 6;

  // lane-value write: bit 0 / bit 8 carry the value, other ones select bits
  function automatic logic [WORD_W-1:0] lane_write(input logic [WORD_W-1:0] cur,
                                                   input logic [WORD_W-1:0] wd);
    logic [WORD_W-1:0] r;
    r = cur;
    for (int i = 1; i < WORD_W; i++) begin
      if (i != 8 && wd[i]) r[i] = (i < 8) ? wd[0] : wd[8];
    end
    return r;
  endfunction
endpackage

// File: rtl/pcsr_errcnt.sv
module pcsr_errcnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev,
  input  logic         clr,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] CMAX = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = ev | clr;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                      cnt_d = ev ? ONE : '0;
    else if (ev && cnt_q != CMAX) cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CMAX && !clr) |=> (cnt_q == CMAX));
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ev) |=> (cnt_q == '0));
  a_r9_read_keeps_event: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && ev) |=> (cnt_q == ONE));
endmodule

// File: rtl/pcsr_irq.sv
module pcsr_irq import pcsr_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  ev,
  input  logic              wr_clr,
  input  logic              wr_mask,
  input  logic [N_IRQ-1:0]  wsel,
  input  logic              irq_en,
  output logic              irq,
  output logic [WORD_W-1:0] st_word,
  output logic [WORD_W-1:0] mk_word
);
  logic [N_IRQ-1:0] st_q, st_d, mk_q, clr_vec;
  logic             st_en;

  assign clr_vec = wr_clr ? wsel : '0;
  assign st_en   = (|ev) | wr_clr;
  assign st_d    = (st_q & ~clr_vec) | ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (st_en) st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mk_q <= '0;
    else if (wr_mask) mk_q <= wsel;
  end

  always_comb begin
    st_word = '0;
    mk_word = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      st_word[IRQ_POS[i]] = st_q[i];
      mk_word[IRQ_POS[i]] = mk_q[i];
    end
  end

  assign irq = irq_en & (|(st_q & mk_q));

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|st_q) |=> ((st_q & $past(st_q & ~clr_vec)) == $past(st_q & ~clr_vec)));
  a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~ev)) |=> ((st_q & $past(clr_vec & ~ev)) == '0));
  a_r5_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((st_q & $past(ev)) == $past(ev)));
endmodule

// File: rtl/pcsr_optreg.sv
module pcsr_optreg import pcsr_pkg::*; #(
  parameter int unsigned EE_LOAD_CYCLES = 30000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wdata,
  input  logic              tx_ack,
  input  logic              adv_ack,
  output logic [WORD_W-1:0] opt_lo,
  output logic [WORD_W-1:0] opt_hi
);
  localparam int unsigned CNT_W = (EE_LOAD_CYCLES < 2) ? 1 : $clog2(EE_LOAD_CYCLES);
  localparam logic [CNT_W-1:0] CNT_START = CNT_W'(EE_LOAD_CYCLES - 1);

  logic [WORD_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic              busy_q, busy_d, ld_start;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  assign lo_d     = lane_write(lo_q, wdata);
  assign ld_start = wr_hi && wdata[CMD_MEMLOAD] && wdata[0] && !busy_q;

  always_comb begin
    hi_d = hi_q;
    if (tx_ack)  hi_d[CMD_TX]  = 1'b0;
    if (adv_ack) hi_d[CMD_ADV] = 1'b0;
    if (wr_hi)   hi_d = lane_write(hi_d, wdata);
    hi_d[CMD_MEMLOAD] = 1'b0;
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (ld_start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_START;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (wr_lo) lo_q <= lo_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          hi_q <= '0;
    else if (wr_hi || tx_ack || adv_ack) hi_q <= hi_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (ld_start || busy_q) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    opt_hi = hi_q;
    opt_hi[CMD_MEMLOAD] = busy_q;
  end
  assign opt_lo = lo_q;

  a_r7_tx_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ack && !wr_hi) |=> !opt_hi[CMD_TX]);
  a_r7_adv_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_ack && !wr_hi) |=> !opt_hi[CMD_ADV]);
  a_r8_load_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));
  a_r3_lane_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (!opt_lo[0] && !opt_lo[8]));
endmodule

// File: rtl/paged_csr_block.sv
module paged_csr_block import pcsr_pkg::*; #(
  parameter logic [WORD_W-1:0] HW_ID          = 16'h4850,
  parameter logic [11:0]       CARD_ID        = 12'h5A3,
  parameter int unsigned       EE_LOAD_CYCLES = 30000,
  parameter int unsigned       DROP_W         = 12,
  parameter int unsigned       ERR_W          = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              ev_rx_pkt,
  input  logic              ev_rx_err,
  input  logic              ev_tx_space,
  input  logic              ev_tx_cmpl,
  input  logic              ev_tx_err,
  input  logic              ev_drop,
  input  logic              ev_crc,
  input  logic              ev_abort,
  input  logic              tx_ack,
  input  logic              adv_ack,
  output logic              irq,
  output logic              core_rst_n,
  output logic              tx_req,
  output logic              adv_req
);
  logic [PAGE_W-1:0] page_q;
  logic              wr_page, on_perf, on_lan;
  logic              wr_lo, wr_hi, wr_st, wr_mk, clr_drop, clr_errs;
  logic [WORD_W-1:0] opt_lo, opt_hi, st_word, mk_word;
  logic [N_IRQ-1:0]  irq_ev, irq_wsel;
  logic [DROP_W-1:0] drop_cnt;
  logic [ERR_W-1:0]  crc_cnt, abort_cnt;

  // page decode and access strobes
  assign on_perf  = (page_q == PG_PERF);
  assign on_lan   = (page_q == PG_LAN);
  assign wr_page  = bus_wr && bus_addr == OFS_PAGE;
  assign wr_lo    = bus_wr && bus_addr == OFS_OPT_LO;
  assign wr_hi    = bus_wr && bus_addr == OFS_OPT_HI;
  assign wr_st    = bus_wr && on_perf && bus_addr == OFS_IRQ_ST;
  assign wr_mk    = bus_wr && on_perf && bus_addr == OFS_IRQ_MK;
  assign clr_drop = bus_rd && on_lan && bus_addr == OFS_DROP;
  assign clr_errs = bus_rd && on_lan && bus_addr == OFS_ERRS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       page_q <= PG_PERF;
    else if (wr_page) page_q <= bus_wdata[PAGE_W-1:0];
  end

  assign irq_ev = {ev_tx_err, ev_tx_cmpl, ev_tx_space, ev_rx_err, ev_rx_pkt};

  for (genvar g = 0; g < N_IRQ; g++) begin : g_wsel
    assign irq_wsel[g] = bus_wdata[IRQ_POS[g]];
  end

  pcsr_optreg #(.EE_LOAD_CYCLES(EE_LOAD_CYCLES)) u_opt (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(bus_wdata),
    .tx_ack(tx_ack), .adv_ack(adv_ack), .opt_lo(opt_lo), .opt_hi(opt_hi)
  );

  pcsr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ev(irq_ev), .wr_clr(wr_st), .wr_mask(wr_mk),
    .wsel(irq_wsel), .irq_en(opt_lo[OPT_IRQ_EN]), .irq(irq),
    .st_word(st_word), .mk_word(mk_word)
  );

  pcsr_errcnt #(.W(DROP_W)) u_drop (
    .clk(clk), .rst_n(rst_n), .ev(ev_drop), .clr(clr_drop), .count(drop_cnt));
  pcsr_errcnt #(.W(ERR_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .ev(ev_crc), .clr(clr_errs), .count(crc_cnt));
  pcsr_errcnt #(.W(ERR_W)) u_abort (
    .clk(clk), .rst_n(rst_n), .ev(ev_abort), .clr(clr_errs), .count(abort_cnt));

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_ID:     bus_rdata = HW_ID;
      OFS_PAGE:   bus_rdata = {CARD_ID, PSEL_W'(page_q)};
      OFS_OPT_LO: bus_rdata = opt_lo;
      OFS_OPT_HI: bus_rdata = opt_hi;
      OFS_IRQ_ST: if (on_perf) bus_rdata = st_word;
      OFS_IRQ_MK: if (on_perf) bus_rdata = mk_word;
      OFS_DROP:   if (on_lan)  bus_rdata = WORD_W'(drop_cnt);
      OFS_ERRS:   if (on_lan)  bus_rdata = {8'(abort_cnt), 8'(crc_cnt)};
      default:    bus_rdata = '0;
    endcase
  end

  assign core_rst_n = opt_lo[OPT_CORE_RUN];
  assign tx_req     = opt_hi[CMD_TX];
  assign adv_req    = opt_hi[CMD_ADV];

  a_r2_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_page |=> $stable(page_q));
  a_r11_status_off_page: assert property (@(posedge clk) disable iff (!rst_n)
    (!on_perf && !(|irq_ev)) |=> $stable(st_word));
endmodule

// File: tb/paged_csr_block_bench.sv
module paged_csr_block_bench;
  localparam int EE_N = 20;
  localparam logic [15:0] HWID = 16'h4850;
  localparam logic [11:0] CID  = 12'h5A3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_wdata, bus_rdata;
  logic ev_rx_pkt, ev_rx_err, ev_tx_space, ev_tx_cmpl, ev_tx_err;
  logic ev_drop, ev_crc, ev_abort, tx_ack, adv_ack;
  logic irq, core_rst_n, tx_req, adv_req;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // reference model state
  int          m_page, m_drop, m_crc, m_abt, m_ecnt;
  bit          m_busy;
  logic [15:0] m_lo, m_hi, m_st, m_mk;

  always #10 clk = ~clk;

  paged_csr_block #(.HW_ID(HWID), .CARD_ID(CID), .EE_LOAD_CYCLES(EE_N)) u_paged_csr_block (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_rx_pkt(ev_rx_pkt), .ev_rx_err(ev_rx_err), .ev_tx_space(ev_tx_space),
    .ev_tx_cmpl(ev_tx_cmpl), .ev_tx_err(ev_tx_err), .ev_drop(ev_drop), .ev_crc(ev_crc),
    .ev_abort(ev_abort), .tx_ack(tx_ack), .adv_ack(adv_ack),
    .irq(irq), .core_rst_n(core_rst_n), .tx_req(tx_req), .adv_req(adv_req));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    ev_rx_pkt = 0; ev_rx_err = 0; ev_tx_space = 0; ev_tx_cmpl = 0; ev_tx_err = 0;
    ev_drop = 0; ev_crc = 0; ev_abort = 0; tx_ack = 0; adv_ack = 0;
  endtask

  function automatic logic [15:0] lanes(input logic [15:0] cur, input logic [15:0] wd);
    logic [15:0] r = cur;
    for (int b = 1; b < 16; b++)
      if (b != 8 && wd[b]) r[b] = (b >= 9) ? wd[8] : wd[0];
    return r;
  endfunction

  function automatic logic [15:0] model_read(input logic [4:0] a);
    case (a)
      5'h00: return HWID;
      5'h02: return {CID, 4'(m_page)};
      5'h04: return m_lo;
      5'h06: return m_hi | (m_busy ? 16'h0040 : 16'h0000);
      5'h08: return (m_page == 0) ? m_st : 16'h0;
      5'h0A: return (m_page == 0) ? m_mk : 16'h0;
      5'h10: return (m_page == 4) ? 16'(m_drop) : 16'h0;
      5'h12: return (m_page == 4) ? {8'(m_abt), 8'(m_crc)} : 16'h0;
      default: return 16'h0;
    endcase
  endfunction

  task automatic model_edge();
    logic [15:0] ev, clr;
    bit start;
    start = bus_wr && bus_addr == 5'h06 && bus_wdata[6] && bus_wdata[0] && !m_busy;
    if (start) begin m_busy = 1; m_ecnt = EE_N; end
    else if (m_busy) begin m_ecnt--; if (m_ecnt == 0) m_busy = 0; end
    if (tx_ack)  m_hi[1] = 0;
    if (adv_ack) m_hi[2] = 0;
    if (bus_wr && bus_addr == 5'h06) m_hi = lanes(m_hi, bus_wdata);
    m_hi[6] = 0;
    if (bus_wr && bus_addr == 5'h04) m_lo = lanes(m_lo, bus_wdata);
    ev = {5'b0, ev_rx_pkt, ev_rx_err, 4'b0, ev_tx_space, ev_tx_cmpl, 1'b0, ev_tx_err, 1'b0};
    clr = (bus_wr && m_page == 0 && bus_addr == 5'h08) ? (bus_wdata & 16'h061A) : 16'h0;
    m_st = (m_st & ~clr) | ev;
    if (bus_wr && m_page == 0 && bus_addr == 5'h0A) m_mk = bus_wdata & 16'h061A;
    if (bus_rd && m_page == 4 && bus_addr == 5'h10) m_drop = ev_drop ? 1 : 0;
    else if (ev_drop && m_drop < 4095) m_drop++;
    if (bus_rd && m_page == 4 && bus_addr == 5'h12) begin
      m_crc = ev_crc ? 1 : 0; m_abt = ev_abort ? 1 : 0;
    end else begin
      if (ev_crc && m_crc < 255) m_crc++;
      if (ev_abort && m_abt < 255) m_abt++;
    end
    if (bus_wr && bus_addr == 5'h02) m_page = int'(bus_wdata[2:0]);
  endtask

  // one clock: read check before the edge, outputs checked at the next falling edge
  task automatic step(input string tag);
    #2;
    if (bus_rd) chk(tag, bus_rdata, model_read(bus_addr));
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R4 core_rst_n", 16'(core_rst_n), 16'(m_lo[1]));
    chk("R6 irq", 16'(irq), 16'(m_lo[2] && ((m_st & m_mk) != 0)));
    chk("R7 tx_req", 16'(tx_req), 16'(m_hi[1]));
    chk("R7 adv_req", 16'(adv_req), 16'(m_hi[2]));
    idle_inputs();
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d, input string tag);
    bus_addr = a; bus_wr = 1; bus_wdata = d; step(tag);
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    bus_addr = a; bus_rd = 1; step(tag);
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", 16'(irq), 16'h0);
    chk("R1 core_rst_n in reset", 16'(core_rst_n), 16'h0);
    chk("R1 tx_req in reset", 16'(tx_req), 16'h0);
    m_page = 0; m_lo = 0; m_hi = 0; m_st = 0; m_mk = 0;
    m_drop = 0; m_crc = 0; m_abt = 0; m_busy = 0; m_ecnt = 0;
    rst_n = 1;
    // R1 reset values
    rd(5'h02, "R1 page"); rd(5'h04, "R1 opt lo"); rd(5'h06, "R1 opt hi");
    rd(5'h08, "R1 status"); rd(5'h0A, "R1 mask");
    wr(5'h02, 16'h0004, "R2 select page 4");
    rd(5'h10, "R1 drop"); rd(5'h12, "R1 errs");
    // R2 paging and shared offsets
    wr(5'h02, 16'hFFF5, "R2 page select");
    rd(5'h02, "R2 page readback"); rd(5'h00, "R2 id on page 5");
    // R3 / R4 masked writes
    wr(5'h04, 16'h0007, "R3 set low lane");
    rd(5'h04, "R3 opt lo after set");
    wr(5'h00, 16'hFFFF, "R11 id write");
    rd(5'h00, "R11 id unchanged");
    wr(5'h02, 16'h0000, "R2 back to page 0");
    rd(5'h04, "R2 opt visible on page 0");
    wr(5'h04, 16'hFF00, "R3 set high lane");
    rd(5'h04, "R3 high lane set");
    wr(5'h04, 16'h8000, "R3 clear bit 15");
    rd(5'h04, "R3 single clear");
    wr(5'h04, 16'h0004, "R4 irq enable off");
    rd(5'h04, "R4 lane value zero");
    wr(5'h04, 16'h0005, "R4 irq enable on");
    // R5 / R6 interrupts
    wr(5'h0A, 16'hFFFF, "R6 mask all");
    rd(5'h0A, "R6 mask stored bits");
    ev_rx_pkt = 1; step("R5 rx packet event");
    rd(5'h08, "R5 status rx packet");
    wr(5'h0A, 16'h0002, "R6 mask tx error only");
    ev_tx_err = 1; step("R5 tx error event");
    ev_rx_err = 1; ev_tx_space = 1; ev_tx_cmpl = 1; step("R5 all events");
    rd(5'h08, "R5 status all");
    wr(5'h08, 16'h0002, "R5 clear tx error");
    rd(5'h08, "R5 after clear");
    ev_rx_pkt = 1; wr(5'h08, 16'h0400, "R5 clear with event");
    rd(5'h08, "R5 event wins");
    wr(5'h08, 16'hFFFF, "R5 clear all");
    rd(5'h08, "R5 cleared");
    // R11 page isolation
    ev_tx_cmpl = 1; step("R11 event");
    wr(5'h02, 16'h0001, "R11 page 1");
    wr(5'h08, 16'hFFFF, "R11 clear off page");
    rd(5'h08, "R11 off page read");
    wr(5'h02, 16'h0000, "R11 page 0");
    rd(5'h08, "R11 status kept");
    // R7 command bits
    wr(5'h06, 16'h0003, "R7 set tx");
    step("R7 hold"); step("R7 hold");
    tx_ack = 1; step("R7 tx ack");
    wr(5'h06, 16'h0005, "R7 set adv");
    wr(5'h06, 16'h0003, "R7 set tx");
    tx_ack = 1; adv_ack = 1; wr(5'h06, 16'h0003, "R7 write wins over ack");
    rd(5'h06, "R7 opt hi");
    wr(5'h06, 16'h0002, "R7 software clear");
    // R8 load busy window
    wr(5'h06, 16'h0041, "R8 start load");
    wr(5'h06, 16'h0040, "R8 clear ignored");
    wr(5'h06, 16'h0041, "R8 restart ignored");
    for (int k = 0; k < EE_N + 2; k++) rd(5'h06, "R8 busy window");
    wr(5'h06, 16'h0040, "R8 value zero");
    rd(5'h06, "R8 no start");
    // R9 / R10 counters
    wr(5'h02, 16'h0004, "R9 page 4");
    for (int k = 0; k < 3; k++) begin ev_drop = 1; step("R9 drop event"); end
    rd(5'h10, "R9 drop count");
    rd(5'h10, "R9 drop cleared");
    ev_drop = 1; rd(5'h10, "R9 read with event");
    rd(5'h10, "R9 restart at one");
    for (int k = 0; k < 260; k++) begin
      ev_crc = 1; ev_abort = (k < 3); step("R10 crc events");
    end
    rd(5'h12, "R10 crc saturated");
    rd(5'h12, "R9 errs cleared");
    for (int k = 0; k < 4100; k++) begin ev_drop = 1; step("R10 drop events"); end
    rd(5'h10, "R10 drop saturated");
    wr(5'h02, 16'h0000, "R11 page 0");
    ev_drop = 1; step("R11 drop event");
    rd(5'h10, "R11 counter hidden");
    wr(5'h02, 16'h0004, "R11 page 4");
    rd(5'h10, "R11 counter not cleared");
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule